// File: doc/BRIEF.md
# Byte-Wide Flash Bus Front End

This block sits on the device side of a byte-wide parallel flash memory and is modelled synchronously. A fast internal clock samples the active-low chip-select, output-enable and write-strobe pins, the 19-bit address and the incoming half of the data bus. The chip-select and write-strobe lines pass through glitch filters before they are used. The filtered strobes are decoded into one of four bus states: read, write, output-disabled or standby.

For a read, the block presents the sampled address to the array read port. It then drives the returned byte, or an identification code when the high-voltage identification input is set, through a registered output with a separate enable. For a write, the address is captured when the cycle opens and the data when it closes. The block then gives the command logic a one-cycle pulse carrying both. A write cycle that sees output-enable low is dropped.

An inactivity timer raises a status output once the bus pins have been quiet long enough. This output does not disturb a read that is still driving data. The glitch and inactivity limits are given in picoseconds and turned into cycle counts from the clock-period parameter.

Top module: `flash_bus_fe`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `dq_oe`, `wr_stb` and `auto_stby` at 0 and `wr_addr`/`wr_data` at 0.
- R2: With chip-select and output-enable both low and the write strobe high, `dq_oe` is 1 and `dq_o` carries `rd_data` for the address shown on `rd_addr`. No drive occurs while the write strobe is low.
- R3: `dq_oe` is 0 whenever output-enable is high or chip-select is high, whatever the other pins do.
- R4: The write address is the address present when the later of the two falling strobes (chip-select, write strobe) is accepted. Address changes after that point do not alter `wr_addr`.
- R5: The write data is the `dq_i` value present when the earlier of the two rising strobes is accepted. At that point `wr_stb` is high for exactly one cycle, with `wr_addr` and `wr_data` valid.
- R6: A chip-select or write-strobe level lasting fewer than GLITCH cycles (GLITCH = ceil(5 ns / clock period), 2 at 250 MHz) has no effect. It causes no drive, no write pulse and no interruption of a read. A level held for GLITCH cycles or more is accepted.
- R7: If output-enable is low at any sampled point while the filtered chip-select and write strobe are both low, that write cycle emits no `wr_stb`.
- R8: `auto_stby` rises after IDLE consecutive cycles (IDLE = ceil(150 ns / clock period), 38 at 250 MHz) with no change on chip-select, output-enable, write strobe or address. It clears on the next change, and a read in progress keeps driving while it is high.
- R9: With `hv_id` high and address bit 1 low, a read returns 0x20 when address bit 0 is 0 and 0xE3 when it is 1. With address bit 1 high, the array byte is returned.
- R10: Strobe pins pass one sampling register and the glitch filter, so an accepted level reaches the decode GLITCH+1 cycles after it appears at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip-select pin, active low |
| oe_n | input | 1 | Output-enable pin, active low |
| we_n | input | 1 | Write-strobe pin, active low |
| addr | input | 19 | Address pins |
| dq_i | input | 8 | Data bus, input half |
| dq_o | output | 8 | Data bus, output half |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| hv_id | input | 1 | High-voltage identification flag |
| rd_addr | output | 19 | Array read port address |
| rd_data | input | 8 | Array read port data |
| wr_stb | output | 1 | One-cycle write pulse to the command logic |
| wr_addr | output | 19 | Captured write address |
| wr_data | output | 8 | Captured write data |
| auto_stby | output | 1 | Automatic standby status |

## Verification
The assertions assume that the pins are driven between clock edges. They also assume that a level meant to count as real lasts at least four cycles, so that counting quiet cycles at the pins stays ahead of the sampling register and filter pipeline. The bench changes every pin on the falling clock edge and holds each accepted strobe level for three or more cycles. It keeps the address and data steady for at least four cycles around every accepted strobe edge, so the capture point is unambiguous. Glitches are deliberately one cycle long, and the idle gaps run well past the IDLE count so the standby status has time to rise.

// File: rtl/flash_fe_pkg.sv
// Shared types, identification codes and time-to-cycle conversion for the
// byte-wide flash bus front end. Assumes all times are given in picoseconds.
package flash_fe_pkg;

    // Decoded bus state after strobe filtering.
    typedef enum logic [1:0] {
        OP_STANDBY = 2'd0,
        OP_OUTDIS  = 2'd1,
        OP_READ    = 2'd2,
        OP_WRITE   = 2'd3
    } bus_op_e;

    localparam logic [7:0] MFR_CODE = 8'h20;
    localparam logic [7:0] DEV_CODE = 8'hE3;

    // Round a duration up to a whole number of clock cycles (minimum 1).
    function automatic int unsigned ps_to_cycles(input int unsigned dur_ps,
                                                 input int unsigned clk_ps);
        int unsigned n;
        n = (dur_ps + clk_ps - 1) / clk_ps;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/fe_glitch_filter.sv
// Level filter for one strobe. The output follows the input only after the
// input has differed from it for HOLD_CYC consecutive samples; shorter
// excursions are discarded. Assumes the input is already synchronous.
module fe_glitch_filter #(
    parameter int unsigned HOLD_CYC = 2,
    parameter logic        INIT     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] run;

    // Count consecutive disagreeing samples and accept the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= INIT;
            run   <= '0;
        end else if (raw == clean) begin
            run <= '0;
        end else if (run == CW'(HOLD_CYC - 1)) begin
            clean <= raw;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/fe_write_latch.sv
// Write-cycle capture. The cycle opens when both filtered strobes are low and
// closes when either rises; the address is taken at the opening, the data at
// the closing, where a one-cycle pulse is issued unless output-enable was seen
// low while the cycle was open. Assumes cyc_act comes from filtered strobes.
module fe_write_latch #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_act,
    input  logic              oe_hi,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              stb,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    logic act_q;
    logic abort;

    // Track cycle edges, latch address/data and raise the pulse at cycle close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            abort  <= 1'b0;
            stb    <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            act_q <= cyc_act;
            stb   <= 1'b0;
            if (cyc_act && !act_q) begin
                addr_q <= addr_in;
                abort  <= !oe_hi;
            end else if (cyc_act && !oe_hi) begin
                abort <= 1'b1;
            end
            if (!cyc_act && act_q) begin
                stb    <= !abort;
                data_q <= data_in;
            end
        end
    end

endmodule

// File: rtl/fe_idle_timer.sv
// Inactivity timer. Compares the monitored pin vector with its previous
// sample and counts unchanged cycles, saturating at IDLE_CYC; the flag is
// high while the count sits at the limit. Assumes a synchronous input vector.
module fe_idle_timer #(
    parameter int unsigned     W        = 22,
    parameter int unsigned     IDLE_CYC = 38,
    parameter logic [W-1:0]    RST_VEC  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mon,
    output logic         idle
);
    localparam int unsigned IW = $clog2(IDLE_CYC + 1);

    logic [W-1:0]  prev;
    logic [IW-1:0] quiet;

    // Keep the previous sample and count quiet cycles up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= RST_VEC;
            quiet <= '0;
        end else begin
            prev <= mon;
            if (mon != prev) begin
                quiet <= '0;
            end else if (quiet != IW'(IDLE_CYC)) begin
                quiet <= quiet + 1'b1;
            end
        end
    end

    assign idle = (quiet == IW'(IDLE_CYC));

endmodule

// File: rtl/flash_bus_fe.sv
// Device-side bus front end of a byte-wide flash. Samples the pins once,
// filters chip-select and write strobe, decodes the bus state, drives read
// or identification data, captures write cycles and reports inactivity.
// Assumes all pins change away from the clock edge and ADDR_W >= 2.
module flash_bus_fe
    import flash_fe_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 4000,
    parameter int unsigned GLITCH_PS = 5000,
    parameter int unsigned IDLE_PS   = 150000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    input  logic              hv_id,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              auto_stby
);
    localparam int unsigned GLITCH_CYC = ps_to_cycles(GLITCH_PS, CLK_PS);
    localparam int unsigned IDLE_CYC   = ps_to_cycles(IDLE_PS, CLK_PS);
    localparam int unsigned NSTROBE    = 2;
    localparam int unsigned MON_W      = 3 + ADDR_W;

    logic              s_ce, s_oe, s_we, s_hv;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_dq;

    // Single sampling stage for every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ce   <= 1'b1;
            s_oe   <= 1'b1;
            s_we   <= 1'b1;
            s_hv   <= 1'b0;
            s_addr <= '0;
            s_dq   <= '0;
        end else begin
            s_ce   <= ce_n;
            s_oe   <= oe_n;
            s_we   <= we_n;
            s_hv   <= hv_id;
            s_addr <= addr;
            s_dq   <= dq_i;
        end
    end

    logic [NSTROBE-1:0] raw_str, cln_str;
    logic               ce_f, we_f;
    assign raw_str = {s_we, s_ce};

    for (genvar g = 0; g < NSTROBE; g++) begin : g_filt
        fe_glitch_filter #(
            .HOLD_CYC (GLITCH_CYC),
            .INIT     (1'b1)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_str[g]),
            .clean (cln_str[g])
        );
    end

    assign ce_f = cln_str[0];
    assign we_f = cln_str[1];

    bus_op_e op;
    logic    wr_act;

    // Decode the bus state from the filtered strobes and sampled output-enable.
    always_comb begin
        if (ce_f)               op = OP_STANDBY;
        else if (!we_f && s_oe) op = OP_WRITE;
        else if (we_f && !s_oe) op = OP_READ;
        else                    op = OP_OUTDIS;
    end

    assign wr_act = !ce_f && !we_f;

    logic              id_sel;
    logic [DATA_W-1:0] id_code;
    assign id_sel  = s_hv && !s_addr[1];
    assign id_code = s_addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
    assign rd_addr = s_addr;

    // Register the read data and its drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe <= 1'b0;
            dq_o  <= '0;
        end else begin
            dq_oe <= (op == OP_READ);
            dq_o  <= id_sel ? id_code : rd_data;
        end
    end

    fe_write_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_act (wr_act),
        .oe_hi   (s_oe),
        .addr_in (s_addr),
        .data_in (s_dq),
        .stb     (wr_stb),
        .addr_q  (wr_addr),
        .data_q  (wr_data)
    );

    fe_idle_timer #(
        .W        (MON_W),
        .IDLE_CYC (IDLE_CYC),
        .RST_VEC  ({3'b111, {ADDR_W{1'b0}}})
    ) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .mon   ({s_ce, s_oe, s_we, s_addr}),
        .idle  (auto_stby)
    );

endmodule

// File: rtl/flash_bus_fe_chk.sv
// Property checker for flash_bus_fe. Counts how long pins have held a level
// at the ports and relates that to the drive enable, write pulse and standby
// status. Assumes pins change between clock edges.
module flash_bus_fe_chk #(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned IDLE_CYC = 38
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic              wr_stb,
    input logic              wr_act,
    input logic              auto_stby
);
    logic [3:0]        ce_hi, oe_hi, we_lo;
    logic [15:0]       quiet;
    logic [ADDR_W+2:0] prev_pins;
    logic              past_rst = 1'b0;

    // Port-level run-length counters for strobe levels and pin quietness.
    always_ff @(posedge clk) begin
        past_rst <= !rst_n;
        if (!rst_n) begin
            ce_hi     <= '0;
            oe_hi     <= '0;
            we_lo     <= '0;
            quiet     <= '0;
            prev_pins <= {ce_n, oe_n, we_n, addr};
        end else begin
            ce_hi     <= ce_n ? ((ce_hi == 4'hF) ? ce_hi : ce_hi + 1'b1) : 4'h0;
            oe_hi     <= oe_n ? ((oe_hi == 4'hF) ? oe_hi : oe_hi + 1'b1) : 4'h0;
            we_lo     <= !we_n ? ((we_lo == 4'hF) ? we_lo : we_lo + 1'b1) : 4'h0;
            prev_pins <= {ce_n, oe_n, we_n, addr};
            if ({ce_n, oe_n, we_n, addr} != prev_pins) quiet <= '0;
            else if (quiet != 16'hFFFF)                quiet <= quiet + 1'b1;
        end
    end

    // R1: state just after a reset edge is quiet.
    always @(posedge clk) begin
        if (past_rst == 1'b1)
            assert_reset_quiet_R1: assert (!wr_stb && !dq_oe && !auto_stby);
    end

    assert_hiz_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_hi >= 4'd4 || oe_hi >= 4'd4) |-> !dq_oe);

    assert_no_drive_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo >= 4'd4) |-> !dq_oe);

    assert_stb_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_stb_after_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(wr_act, 2) && !$past(wr_act)));

    assert_stby_needs_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_stby) |-> (quiet >= 16'(IDLE_CYC - 4)));

endmodule

bind flash_bus_fe flash_bus_fe_chk #(
    .ADDR_W   (ADDR_W),
    .IDLE_CYC (IDLE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .dq_oe     (dq_oe),
    .wr_stb    (wr_stb),
    .wr_act    (wr_act),
    .auto_stby (auto_stby)
);

// File: tb/sim_flash_bus_fe.sv
`timescale 1ns/1ps
// Bench for flash_bus_fe: a behavioural per-cycle model built from the
// requirements, compared against every output after every clock edge.
module sim_flash_bus_fe;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int GL = 2;    // ceil(5 ns / 4 ns)
    localparam int IDL = 38;  // ceil(150 ns / 4 ns)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hv_id = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o, rd_data, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          dq_oe, wr_stb, auto_stby;

    always #2 clk = ~clk;

    function automatic logic [7:0] arr_byte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    assign rd_data = arr_byte(rd_addr);

    flash_bus_fe u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .hv_id(hv_id),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .auto_stby(auto_stby)
    );

    int    n_vec = 0, n_bad = 0, n_stb = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic          m_sce = 1, m_soe = 1, m_swe = 1, m_shv = 0;
    logic [AW-1:0] m_sa = '0;
    logic [DW-1:0] m_sd = '0;
    logic          m_cef = 1, m_wef = 1, m_pact = 0, m_abort = 0;
    int            m_cec = 0, m_wec = 0, m_idle = 0;
    logic          m_pce = 1, m_poe = 1, m_pwe = 1;
    logic [AW-1:0] m_pa = '0, m_wa = '0;
    logic [DW-1:0] m_wd = '0, m_do = '0;
    logic          m_oe = 0, m_stb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sce = 1; m_soe = 1; m_swe = 1; m_shv = 0; m_sa = '0; m_sd = '0;
            m_cef = 1; m_wef = 1; m_cec = 0; m_wec = 0; m_pact = 0; m_abort = 0;
            m_pce = 1; m_poe = 1; m_pwe = 1; m_pa = '0; m_idle = 0;
            m_wa = '0; m_wd = '0; m_do = '0; m_oe = 0; m_stb = 0;
        end else begin
            logic act;
            logic chg;
            m_oe = !m_cef && m_wef && !m_soe;
            if (m_shv && !m_sa[1]) m_do = m_sa[0] ? 8'hE3 : 8'h20;
            else                   m_do = arr_byte(m_sa);
            act = !m_cef && !m_wef;
            m_stb = 0;
            if (act && !m_pact) begin m_wa = m_sa; m_abort = !m_soe; end
            else if (act && !m_soe) m_abort = 1;
            if (!act && m_pact) begin m_stb = !m_abort; m_wd = m_sd; end
            m_pact = act;
            chg = (m_sce != m_pce) || (m_soe != m_poe) || (m_swe != m_pwe) || (m_sa != m_pa);
            m_pce = m_sce; m_poe = m_soe; m_pwe = m_swe; m_pa = m_sa;
            if (chg) m_idle = 0; else if (m_idle < IDL) m_idle++;
            if (m_sce != m_cef) begin m_cec++; if (m_cec >= GL) begin m_cef = m_sce; m_cec = 0; end end
            else m_cec = 0;
            if (m_swe != m_wef) begin m_wec++; if (m_wec >= GL) begin m_wef = m_swe; m_wec = 0; end end
            else m_wec = 0;
            m_sce = ce_n; m_soe = oe_n; m_swe = we_n; m_shv = hv_id; m_sa = addr; m_sd = dq_i;
        end
    end

    // Compare every output shortly after each edge.
    always @(posedge clk) begin
        #1;
        chk(dq_oe === m_oe, cur_req, "dq_oe", dq_oe, m_oe);
        if (m_oe) chk(dq_o === m_do, cur_req, "dq_o", dq_o, m_do);
        chk(wr_stb === m_stb, cur_req, "wr_stb", wr_stb, m_stb);
        chk(wr_addr === m_wa, cur_req, "wr_addr", wr_addr, m_wa);
        chk(wr_data === m_wd, cur_req, "wr_data", wr_data, m_wd);
        chk(auto_stby === (m_idle == IDL), cur_req, "auto_stby", auto_stby, (m_idle == IDL));
        if (wr_stb === 1'b1) n_stb++;
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic hv);
        addr = a; hv_id = hv; tick(1);
        ce_n = 0; oe_n = 0; tick(8);
        oe_n = 1; ce_n = 1; tick(5);
    endtask

    // Strobe order: ce_first=1 -> chip-select falls first, write strobe rises first.
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_first);
        addr = a ^ 19'h7FFFF; tick(1);
        if (ce_first) ce_n = 0; else we_n = 0;
        tick(3);
        addr = a; tick(4);
        if (ce_first) we_n = 0; else ce_n = 0;
        tick(5);
        addr = a ^ 19'h00F0F; dq_i = d; tick(4);
        if (ce_first) we_n = 1; else ce_n = 1;
        tick(5);
        dq_i = ~d;
        if (ce_first) ce_n = 1; else we_n = 1;
        tick(5);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int s0;
        cur_req = "R1";
        tick(4);
        chk(dq_oe === 0 && wr_stb === 0 && auto_stby === 0, "R1", "reset outputs",
            {dq_oe, wr_stb, auto_stby}, 0);
        rst_n = 1; tick(3);

        cur_req = "R2";
        bus_read(19'h12345, 0);
        bus_read(19'h7ABCD, 0);
        addr = 19'h00444; ce_n = 0; oe_n = 0; tick(6);
        chk(dq_oe === 1 && dq_o === arr_byte(19'h00444), "R2", "read byte", dq_o, arr_byte(19'h00444));
        cur_req = "R10";
        addr = 19'h00445; tick(2);
        chk(dq_o === arr_byte(19'h00445), "R10", "read follows address", dq_o, arr_byte(19'h00445));
        cur_req = "R6";
        ce_n = 1; tick(1); ce_n = 0; tick(4);
        chk(dq_oe === 1, "R6", "read kept through chip-select glitch", dq_oe, 1);
        cur_req = "R3";
        oe_n = 1; tick(4);
        chk(dq_oe === 0, "R3", "output disabled", dq_oe, 0);
        oe_n = 0; ce_n = 1; tick(5);
        chk(dq_oe === 0, "R3", "standby with oe low", dq_oe, 0);
        oe_n = 1; tick(3);

        cur_req = "R9";
        bus_read(19'h00000, 1);
        bus_read(19'h00001, 1);
        bus_read(19'h00002, 1);
        addr = 19'h00001; hv_id = 1; ce_n = 0; oe_n = 0; tick(6);
        chk(dq_o === 8'hE3, "R9", "device code", dq_o, 8'hE3);
        oe_n = 1; ce_n = 1; hv_id = 0; tick(4);

        cur_req = "R4";
        s0 = n_stb;
        bus_write(19'h2A5A5, 8'h3C, 1);
        chk(wr_addr === 19'h2A5A5 && wr_data === 8'h3C, "R4", "we-controlled capture", wr_addr, 19'h2A5A5);
        cur_req = "R5";
        bus_write(19'h05123, 8'hC7, 0);
        chk(wr_data === 8'hC7, "R5", "ce-controlled data", wr_data, 8'hC7);
        chk(n_stb - s0 == 2, "R5", "pulse count", n_stb - s0, 2);

        cur_req = "R6";
        s0 = n_stb;
        oe_n = 0; ce_n = 0; tick(1); ce_n = 1; tick(5);
        chk(dq_oe === 0, "R6", "chip-select glitch causes no drive", dq_oe, 0);
        oe_n = 1; ce_n = 0; tick(4);
        we_n = 0; tick(1); we_n = 1; tick(6);
        ce_n = 1; tick(4);
        chk(n_stb == s0, "R6", "write-strobe glitch causes no pulse", n_stb - s0, 0);

        cur_req = "R7";
        s0 = n_stb;
        addr = 19'h11111; ce_n = 0; tick(3); we_n = 0; tick(4);
        oe_n = 0; tick(3); oe_n = 1; tick(3);
        we_n = 1; tick(5); ce_n = 1; tick(5);
        chk(n_stb == s0, "R7", "aborted write", n_stb - s0, 0);

        cur_req = "R8";
        tick(IDL + 6);
        chk(auto_stby === 1, "R8", "idle standby", auto_stby, 1);
        addr = 19'h03030; tick(3);
        chk(auto_stby === 0, "R8", "activity clears standby", auto_stby, 0);
        ce_n = 0; oe_n = 0; tick(IDL + 8);
        chk(auto_stby === 1 && dq_oe === 1 && dq_o === arr_byte(19'h03030), "R8",
            "read held in standby", {auto_stby, dq_oe}, 3);
        oe_n = 1; ce_n = 1; tick(6);

        cur_req = "R1";
        rst_n = 0; tick(2);
        chk(dq_oe === 0 && wr_stb === 0 && auto_stby === 0 && wr_addr === 0, "R1",
            "second reset", {dq_oe, wr_stb, auto_stby}, 0);
        rst_n = 1; tick(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule